// File: doc/BRIEF.md
# FPGA Slave-Serial Boot Sequencer

This block controls how an SRAM-based FPGA gets its configuration from a removable memory card. A card reader, which handles the card protocol, supplies a byte stream from a start address that the sequencer gives it. The sequencer pulses the target's program line, waits for the target's init line, and then clocks the bytes into the target one bit per serial clock, most significant bit first, until the target raises done. A second mode sends the same byte stream as plain clocked serial data to any target that asks for it with a request line.

Images are stored on the card on 256 KiB boundaries and are grouped into sets of `IMGS_PER_SET` images. External switches pick the set at boot time. The first load of a boot cycle always uses image 0 of the set. Each later reconfiguration request from the target moves to the next image of the set, which supports multi-stage bootstrapping. A boot cycle starts when a card is present at power-up or when a card is inserted.

Top module: `fpga_boot_seq`

## Requirements
- R1: While reset is applied, prog_n is 1 and ser_clk, ser_dat, rd_start, rd_stop, byte_ready and boot_err are all 0.
- R2: A boot cycle starts on the first clock where card_present is seen high after reset, or after it was low. At that clock the sequencer latches set_sel and data_mode and sets the image index to 0.
- R3: In configuration mode each load holds prog_n low for exactly PROG_CYC cycles. It then waits for tgt_init to be high. Then it gives a one-cycle rd_start pulse together with rd_addr.
- R4: rd_addr equals (set × IMGS_PER_SET + index) × 0x40000, where set is the latched switch value.
- R5: Each accepted byte is sent MSB first, two cycles per bit. In the first cycle ser_clk is 0 and ser_dat holds the bit; in the second cycle ser_clk is 1. A new byte may be taken during the high cycle of the previous byte's last bit. byte_ready is 1 only while streaming.
- R6: In configuration mode, tgt_done high while streaming ends the stream. rd_stop pulses for one cycle, ser_clk stays 0 afterwards, and boot_err stays 0.
- R7: In configuration mode, tgt_init low while streaming sets boot_err and ends the stream with a rd_stop pulse. The same happens when the byte flagged byte_last has been fully shifted out and tgt_done is still low. A later load clears boot_err.
- R8: When the sequencer is idle after a configuration load, a reconf_req pulse advances the image index modulo IMGS_PER_SET and reruns the R3 sequence.
- R9: In data mode prog_n is never driven low. dat_req high while idle starts a read of the current image. dat_req low while streaming ends the stream with a rd_stop pulse and advances the image index.
- R10: card_present low returns the sequencer to idle. If a stream was running, rd_stop pulses and the serial outputs go quiet.
- R11: Changes on set_sel or data_mode after a boot cycle has started have no effect on any address until the next card insertion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| card_present | input | 1 | Card detect, high while a card is inserted |
| set_sel | input | SET_W | Switches that select the configuration set |
| data_mode | input | 1 | 1 selects plain data mode, 0 selects configuration mode |
| reconf_req | input | 1 | Request from the target to load the next image |
| dat_req | input | 1 | Data-mode request, held high while bits are wanted |
| rd_start | output | 1 | One-cycle pulse telling the reader to start at rd_addr |
| rd_addr | output | ADDR_W | Byte address of the image start |
| rd_stop | output | 1 | One-cycle pulse telling the reader to stop |
| byte_valid | input | 1 | Reader has a byte on byte_data |
| byte_data | input | 8 | Byte from the reader |
| byte_last | input | 1 | Marks the last byte of the image |
| byte_ready | output | 1 | Sequencer takes the byte this cycle when valid |
| prog_n | output | 1 | Target program line, active low |
| tgt_init | input | 1 | Target init line, high when the target is ready |
| tgt_done | input | 1 | Target done line |
| ser_clk | output | 1 | Configuration or data serial clock |
| ser_dat | output | 1 | Configuration or data serial bit |
| boot_err | output | 1 | Set on a failed configuration load |

## Verification
The hardest state to reach from the ports is the wrap of the image index back to 0 after the last image of a set, with the switches changed in the meantime. Reaching it takes a chain of completed loads. The bench builds this chain with a behavioural target and card reader: the target drops init while program is low and raises done after a chosen number of serial clock rises. Each load therefore ends a different way (done, missing done, init lost), and the set switches are moved before the second load. Card removal during a stream and a re-insertion into data mode then run the same model along a different path.

// File: rtl/boot_seq_pkg.sv
package boot_seq_pkg;

    // Image slots on the card are 256 KiB apart
    localparam int BLOCK_SHIFT = 18;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PROG,
        ST_WAITI,
        ST_STREAM,
        ST_HOLD
    } seq_st_e;

    typedef struct packed {
        logic [7:0] sh;
        logic [3:0] cnt;
        logic       ph;
    } shift_regs_t;

endpackage

// File: rtl/boot_addr_calc.sv
module boot_addr_calc
    import boot_seq_pkg::*;
#(
    parameter int SET_W        = 2,
    parameter int IDX_W        = 2,
    parameter int IMGS_PER_SET = 4,
    parameter int ADDR_W       = 32
) (
    input  logic [SET_W-1:0]  set_i,
    input  logic [IDX_W-1:0]  idx_i,
    output logic [ADDR_W-1:0] addr_o
);

    logic [ADDR_W-1:0] slot;

    always_comb begin
        slot   = ADDR_W'(set_i) * ADDR_W'(IMGS_PER_SET) + ADDR_W'(idx_i);
        addr_o = slot << BLOCK_SHIFT;
    end

endmodule

// File: rtl/boot_bit_shifter.sv
module boot_bit_shifter
    import boot_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load_i,
    input  logic [7:0] byte_i,
    input  logic       flush_i,
    output logic       ser_clk_o,
    output logic       ser_dat_o,
    output logic       empty_o,
    output logic       can_load_o
);

    shift_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (flush_i) begin
            r_d.cnt = 4'd0;
            r_d.ph  = 1'b0;
        end else if (load_i) begin
            r_d.sh  = byte_i;
            r_d.cnt = 4'd8;
            r_d.ph  = 1'b0;
        end else if (r_q.cnt != 4'd0) begin
            if (!r_q.ph) begin
                r_d.ph = 1'b1;
            end else begin
                r_d.ph  = 1'b0;
                r_d.cnt = r_q.cnt - 4'd1;
                r_d.sh  = {r_q.sh[6:0], 1'b0};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign ser_clk_o  = r_q.ph;
    assign ser_dat_o  = (r_q.cnt != 4'd0) & r_q.sh[7];
    assign empty_o    = (r_q.cnt == 4'd0);
    assign can_load_o = (r_q.cnt == 4'd0) | ((r_q.cnt == 4'd1) & r_q.ph);

    AST_DAT_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ser_clk_o) |-> $stable(ser_dat_o)); // R5

    AST_CLK_NEEDS_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        ser_clk_o |-> !empty_o); // R5

endmodule

// File: rtl/fpga_boot_seq.sv
module fpga_boot_seq
    import boot_seq_pkg::*;
#(
    parameter int SET_W        = 2,
    parameter int IMGS_PER_SET = 4,
    parameter int ADDR_W       = 32,
    parameter int PROG_CYC     = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              card_present,
    input  logic [SET_W-1:0]  set_sel,
    input  logic              data_mode,
    input  logic              reconf_req,
    input  logic              dat_req,
    output logic              rd_start,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              rd_stop,
    input  logic              byte_valid,
    input  logic [7:0]        byte_data,
    input  logic              byte_last,
    output logic              byte_ready,
    output logic              prog_n,
    input  logic              tgt_init,
    input  logic              tgt_done,
    output logic              ser_clk,
    output logic              ser_dat,
    output logic              boot_err
);

    localparam int IDX_W = (IMGS_PER_SET > 1) ? $clog2(IMGS_PER_SET) : 1;
    localparam int CNT_W = $clog2(PROG_CYC + 1);
    localparam logic [CNT_W-1:0] PROG_LOAD = CNT_W'(PROG_CYC - 1);
    localparam logic [IDX_W-1:0] IDX_MAX   = IDX_W'(IMGS_PER_SET - 1);

    typedef struct packed {
        seq_st_e           st;
        logic [CNT_W-1:0]  cnt;
        logic              card;
        logic [SET_W-1:0]  set;
        logic              dmode;
        logic [IDX_W-1:0]  idx;
        logic              start;
        logic              stop;
        logic [ADDR_W-1:0] addr;
        logic              err;
        logic              last;
    } seq_regs_t;

    seq_regs_t r_d, r_q;

    logic [ADDR_W-1:0] cur_addr;
    logic [IDX_W-1:0]  idx_next;
    logic streaming, cfg_done, cfg_fault, dat_end, leave;
    logic sh_load, sh_flush, sh_empty, sh_can_load;

    boot_addr_calc #(
        .SET_W(SET_W), .IDX_W(IDX_W), .IMGS_PER_SET(IMGS_PER_SET), .ADDR_W(ADDR_W)
    ) addr_i (
        .set_i (r_q.set),
        .idx_i (r_q.idx),
        .addr_o(cur_addr)
    );

    boot_bit_shifter shift_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (sh_load),
        .byte_i    (byte_data),
        .flush_i   (sh_flush),
        .ser_clk_o (ser_clk),
        .ser_dat_o (ser_dat),
        .empty_o   (sh_empty),
        .can_load_o(sh_can_load)
    );

    always_comb begin
        idx_next   = (r_q.idx == IDX_MAX) ? '0 : r_q.idx + 1'b1;
        streaming  = (r_q.st == ST_STREAM);
        cfg_done   = !r_q.dmode & tgt_done;
        cfg_fault  = !r_q.dmode & (!tgt_init | (r_q.last & sh_empty));
        dat_end    = r_q.dmode & !dat_req;
        leave      = streaming & (cfg_done | cfg_fault | dat_end);
        byte_ready = streaming & card_present & !leave & !r_q.last & sh_can_load;
        sh_load    = byte_ready & byte_valid;
        sh_flush   = leave | !card_present;
    end

    always_comb begin
        r_d       = r_q;
        r_d.start = 1'b0;
        r_d.stop  = 1'b0;
        r_d.card  = card_present;
        if (!card_present) begin
            r_d.st   = ST_IDLE;
            r_d.stop = streaming;
            r_d.last = 1'b0;
        end else if (!r_q.card) begin
            r_d.set   = set_sel;
            r_d.dmode = data_mode;
            r_d.idx   = '0;
            r_d.err   = 1'b0;
            r_d.last  = 1'b0;
            r_d.cnt   = PROG_LOAD;
            r_d.st    = data_mode ? ST_HOLD : ST_PROG;
        end else begin
            unique case (r_q.st)
                ST_PROG: begin
                    if (r_q.cnt == '0) r_d.st  = ST_WAITI;
                    else               r_d.cnt = r_q.cnt - 1'b1;
                end
                ST_WAITI: begin
                    if (tgt_init) begin
                        r_d.start = 1'b1;
                        r_d.addr  = cur_addr;
                        r_d.last  = 1'b0;
                        r_d.st    = ST_STREAM;
                    end
                end
                ST_STREAM: begin
                    if (leave) begin
                        r_d.st   = ST_HOLD;
                        r_d.stop = 1'b1;
                        if (cfg_fault && !tgt_done) r_d.err = 1'b1;
                        if (dat_end) r_d.idx = idx_next;
                    end else if (sh_load) begin
                        r_d.last = byte_last;
                    end
                end
                ST_HOLD: begin
                    if (r_q.dmode) begin
                        if (dat_req) begin
                            r_d.start = 1'b1;
                            r_d.addr  = cur_addr;
                            r_d.last  = 1'b0;
                            r_d.st    = ST_STREAM;
                        end
                    end else if (reconf_req) begin
                        r_d.idx = idx_next;
                        r_d.err = 1'b0;
                        r_d.cnt = PROG_LOAD;
                        r_d.st  = ST_PROG;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign prog_n   = (r_q.st != ST_PROG);
    assign rd_start = r_q.start;
    assign rd_addr  = r_q.addr;
    assign rd_stop  = r_q.stop;
    assign boot_err = r_q.err;

    AST_PROG_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !prog_n |-> (!ser_clk && !byte_ready)); // R3
    AST_START_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_start |=> !rd_start); // R3
    AST_ADDR_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        rd_start |-> (rd_addr[BLOCK_SHIFT-1:0] == '0)); // R4
    AST_STOP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stop |=> !rd_stop); // R6
    AST_ERR_WITH_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(boot_err) |-> rd_stop); // R7
    AST_DATA_NO_PROG: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.dmode |-> prog_n); // R9

endmodule

// File: tb/fpga_boot_seq_tb_top.sv
module fpga_boot_seq_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int SET_W   = 2;
    localparam int IPS     = 4;
    localparam int ADDR_W  = 32;
    localparam int PROG_C  = 5;
    localparam int IMG_LEN = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic card_present = 1'b0;
    logic [SET_W-1:0] set_sel = '0;
    logic data_mode = 1'b0, reconf_req = 1'b0, dat_req = 1'b0;
    logic rd_start, rd_stop, byte_ready, prog_n, ser_clk, ser_dat, boot_err;
    logic [ADDR_W-1:0] rd_addr;
    logic byte_valid = 1'b0, byte_last = 1'b0;
    logic [7:0] byte_data = '0;
    logic tgt_init = 1'b0, tgt_done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fpga_boot_seq #(.SET_W(SET_W), .IMGS_PER_SET(IPS), .ADDR_W(ADDR_W), .PROG_CYC(PROG_C)) dut_i (
        .clk(clk), .rst_n(rst_n), .card_present(card_present), .set_sel(set_sel),
        .data_mode(data_mode), .reconf_req(reconf_req), .dat_req(dat_req),
        .rd_start(rd_start), .rd_addr(rd_addr), .rd_stop(rd_stop),
        .byte_valid(byte_valid), .byte_data(byte_data), .byte_last(byte_last),
        .byte_ready(byte_ready), .prog_n(prog_n), .tgt_init(tgt_init), .tgt_done(tgt_done),
        .ser_clk(ser_clk), .ser_dat(ser_dat), .boot_err(boot_err)
    );

    int checks = 0, failures = 0, cyc = 0;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s: actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // environment knobs
    int done_at = 0, kill_at = 0;
    int hi_cnt = 0, bits = 0;
    bit done_r = 0, clk_prev = 0;
    logic [7:0] rq[$];
    logic [ADDR_W-1:0] starts[$];

    function automatic logic [7:0] byte_val(input logic [ADDR_W-1:0] a, input int k);
        return 8'(a[25:18] * 37 + k * 11 + 5);
    endfunction

    // reference model state
    int m_st = 0, m_cnt = 0, m_set = 0, m_idx = 0;
    bit m_card = 0, m_mode = 0, m_start = 0, m_stop = 0, m_err = 0, m_last = 0, m_ph = 0;
    logic [ADDR_W-1:0] m_addr = '0;
    bit bq[$];

    function automatic logic [ADDR_W-1:0] slot_addr(input int s, input int i);
        return ADDR_W'((s * IPS + i) * 32'h40000);
    endfunction

    function automatic bit m_leave();
        bit empty = (bq.size() == 0);
        if (m_st != 3) return 0;
        if (m_mode) return !dat_req;
        return tgt_done || !tgt_init || (m_last && empty);
    endfunction

    function automatic bit m_ready();
        bit can = (bq.size() == 0) || (bq.size() == 1 && m_ph);
        return (m_st == 3) && card_present && !m_leave() && !m_last && can;
    endfunction

    task automatic model_step();
        bit lv = m_leave();
        bit ld = m_ready() && byte_valid;
        bit fl = lv || !card_present;
        bit empty = (bq.size() == 0);
        bit streaming = (m_st == 3);
        int st0 = m_st;
        m_start = 0; m_stop = 0;
        if (!card_present) begin
            m_st = 0; m_stop = streaming; m_last = 0;
        end else if (!m_card) begin
            m_set = int'(set_sel); m_mode = data_mode; m_idx = 0; m_err = 0; m_last = 0;
            m_cnt = PROG_C - 1; m_st = data_mode ? 4 : 1;
        end else if (st0 == 1) begin
            if (m_cnt == 0) m_st = 2; else m_cnt--;
        end else if (st0 == 2) begin
            if (tgt_init) begin m_start = 1; m_addr = slot_addr(m_set, m_idx); m_last = 0; m_st = 3; end
        end else if (st0 == 3) begin
            if (lv) begin
                m_st = 4; m_stop = 1;
                if (!m_mode && !tgt_done && (!tgt_init || (m_last && empty))) m_err = 1;
                if (m_mode) m_idx = (m_idx + 1) % IPS;
            end else if (ld) m_last = byte_last;
        end else if (st0 == 4) begin
            if (m_mode) begin
                if (dat_req) begin m_start = 1; m_addr = slot_addr(m_set, m_idx); m_last = 0; m_st = 3; end
            end else if (reconf_req) begin
                m_idx = (m_idx + 1) % IPS; m_err = 0; m_cnt = PROG_C - 1; m_st = 1;
            end
        end
        m_card = card_present;
        // shifter
        if (fl) begin bq.delete(); m_ph = 0; end
        else if (ld) begin
            bq.delete();
            for (int b = 7; b >= 0; b--) bq.push_back(byte_data[b]);
            m_ph = 0;
        end else if (bq.size() > 0) begin
            if (!m_ph) m_ph = 1;
            else begin void'(bq.pop_front()); m_ph = 0; end
        end
    endtask

    always @(negedge clk) begin
        #2;
        cyc++;
        // behavioural target
        if (!prog_n) begin hi_cnt = 0; bits = 0; done_r = 0; end
        else if (hi_cnt < 10) hi_cnt++;
        if (ser_clk && !clk_prev) bits++;
        clk_prev = ser_clk;
        if (done_at > 0 && bits >= done_at) done_r = 1;
        tgt_init = prog_n && hi_cnt >= 3 && !(kill_at > 0 && bits >= kill_at);
        tgt_done = done_r;
        // behavioural card reader
        if (rd_stop) rq.delete();
        if (rd_start) begin
            starts.push_back(rd_addr);
            rq.delete();
            for (int k = 0; k < IMG_LEN; k++) rq.push_back(byte_val(rd_addr, k));
        end
        byte_valid = rq.size() > 0;
        byte_data  = (rq.size() > 0) ? rq[0] : 8'h00;
        byte_last  = rq.size() == 1;
        #1;
        if (rst_n) begin
            chk(prog_n == (m_st != 1), "R3 prog_n", prog_n, m_st != 1);
            chk(rd_start == m_start, "R3 rd_start", rd_start, m_start);
            chk(rd_addr == m_addr, "R4 rd_addr", rd_addr, m_addr);
            chk(rd_stop == m_stop, "R6 rd_stop", rd_stop, m_stop);
            chk(ser_clk == (bq.size() > 0 && m_ph), "R5 ser_clk", ser_clk, bq.size() > 0 && m_ph);
            chk(ser_dat == ((bq.size() > 0) ? bq[0] : 1'b0), "R5 ser_dat", ser_dat,
                (bq.size() > 0) ? bq[0] : 1'b0);
            chk(byte_ready == m_ready(), "R5 byte_ready", byte_ready, m_ready());
            chk(boot_err == m_err, "R7 boot_err", boot_err, m_err);
            if (byte_valid && byte_ready) void'(rq.pop_front());
            model_step();
        end
    end

    task automatic wait_stop(input string tag);
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if (rd_stop) return;
        end
        chk(0, tag, 0, 1);
    endtask

    task automatic pulse_reconf();
        @(negedge clk); reconf_req = 1'b1;
        @(negedge clk); reconf_req = 1'b0;
    endtask

    initial begin
        card_present = 1'b1; set_sel = 2'd2; data_mode = 1'b0; done_at = 20;
        repeat (3) @(negedge clk);
        chk(prog_n === 1'b1 && ser_clk === 1'b0 && ser_dat === 1'b0 && rd_start === 1'b0 &&
            rd_stop === 1'b0 && byte_ready === 1'b0 && boot_err === 1'b0, "R1 reset outputs",
            {prog_n, ser_clk, ser_dat, rd_start, rd_stop, byte_ready, boot_err}, 7'b1000000);
        rst_n = 1'b1;
        // load 0: done mid-stream
        wait_stop("R6 stop after done");
        chk(boot_err == 1'b0, "R6 no error on done", boot_err, 0);
        set_sel = 2'd3;                      // R11: must be ignored
        // load 1: done never arrives
        done_at = 0;
        pulse_reconf();
        wait_stop("R7 stop on missing done");
        chk(boot_err == 1'b1, "R7 error on missing done", boot_err, 1);
        // load 2: init lost mid-stream
        kill_at = 10;
        pulse_reconf();
        wait_stop("R7 stop on init loss");
        chk(boot_err == 1'b1, "R7 error on init loss", boot_err, 1);
        kill_at = 0;
        // load 3: done right after the last bit
        done_at = IMG_LEN * 8;
        pulse_reconf();
        wait_stop("R6 stop at final bit");
        chk(boot_err == 1'b0, "R7 error cleared by new load", boot_err, 0);
        // load 4: index wraps
        done_at = 8;
        pulse_reconf();
        wait_stop("R8 stop after wrap");
        // load 5: card pulled mid-stream
        done_at = 0;
        pulse_reconf();
        repeat (PROG_C + 30) @(negedge clk);
        card_present = 1'b0;
        wait_stop("R10 stop on removal");
        repeat (3) @(negedge clk);
        chk(prog_n == 1'b1 && ser_clk == 1'b0 && byte_ready == 1'b0, "R10 quiet after removal",
            {prog_n, ser_clk, byte_ready}, 3'b100);
        // insert into data mode, set 1
        set_sel = 2'd1; data_mode = 1'b1;
        @(negedge clk); card_present = 1'b1;
        repeat (4) @(negedge clk);
        dat_req = 1'b1;
        repeat (60) @(negedge clk);
        dat_req = 1'b0;
        wait_stop("R9 stop on request drop");
        repeat (3) @(negedge clk);
        dat_req = 1'b1;
        repeat (20) @(negedge clk);
        dat_req = 1'b0;
        repeat (5) @(negedge clk);
        // start-address log
        chk(starts.size() == 8, "R4 number of reads", starts.size(), 8);
        if (starts.size() == 8) begin
            chk(starts[0] == slot_addr(2, 0), "R2 first image of set", starts[0], slot_addr(2, 0));
            chk(starts[1] == slot_addr(2, 1), "R11 switches ignored", starts[1], slot_addr(2, 1));
            chk(starts[3] == slot_addr(2, 3), "R8 advance", starts[3], slot_addr(2, 3));
            chk(starts[4] == slot_addr(2, 0), "R8 wrap", starts[4], slot_addr(2, 0));
            chk(starts[6] == slot_addr(1, 0), "R2 insertion latch", starts[6], slot_addr(1, 0));
            chk(starts[7] == slot_addr(1, 1), "R9 data index advance", starts[7], slot_addr(1, 1));
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        chk(0, "watchdog", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule